// File: doc/BRIEF.md
# Half-Bridge Dead-Time Generator

This block takes one PWM command bit and produces two gate enables for a half-bridge: a high-side enable that follows the command, and a low-side enable that is its complement. Each time the command changes level, both enables are held low for a programmed number of reference-clock cycles before the new side turns on. The gap is the same in both directions. It keeps the two switches from conducting together while the upper and lower devices hand over.

A 3-bit mode code selects one of four preset gap lengths or a shutdown state. An undervoltage flag also forces both enables off. The mode code and the flag arrive as clean synchronous digital inputs. All timing is counted in cycles of the block clock. With the default presets of 3, 5, 7 and 9 cycles on a 200 MHz clock, the gaps are 15, 25, 35 and 45 ns. This leaves more than 90 cycles of usable on-time per half period at a 1 MHz switching rate.

Top module: `halfbridge_deadtime`

## Requirements
- R1: While reset is high at a clock edge, both enables are low in the following cycle and the block returns to its off state. After reset is released, a full dead interval passes with both enables low before either side turns on.
- R2: In steady operation the high-side enable equals the PWM input as sampled one clock earlier, and the low-side enable equals its complement.
- R3: Suppose one enable falls after the clock edge at which the PWM input was seen to change. The opposite enable then rises exactly N cycles after that fall, with N the active preset, and this holds for both directions.
- R4: The mode code selects the preset as follows: 0 gives 3 cycles, 1 gives 5, 2 gives 7 and 3 gives 9 (defaults of parameters DEAD_CYC0..DEAD_CYC3).
- R5: The mode code is captured only when a dead interval starts. A change of the code between presets, made during a dead interval or while one side is on, has no effect until the next interval starts.
- R6: Mode codes 4 to 7 mean shutdown. Both enables are low in the cycle after such a code is seen at a clock edge, whatever the PWM input does.
- R7: A high undervoltage flag at a clock edge forces both enables low in the following cycle.
- R8: When the block leaves shutdown or undervoltage, both enables stay low for one full dead interval before either side turns on.
- R9: If the PWM input returns to its previous level during a dead interval, the interval restarts from zero toward the level now requested. The abandoned side never turns on.
- R10: The high-side and low-side enables are never both high in the same cycle.
- R11: A PWM high pulse of L cycles, starting from low-side conduction, gives exactly L−N cycles of high-side enable when L > N, and none when L ≤ N.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous reset, active high |
| pwmIn | input | 1 | PWM command; 1 requests high-side conduction |
| modeCode | input | 3 | Preset select: 0..3 dead-time presets, 4..7 shutdown |
| uvFlag | input | 1 | Undervoltage indication, active high; forces outputs off |
| hiEn | output | 1 | High-side gate enable |
| loEn | output | 1 | Low-side gate enable |

## Verification
The hardest situation to reach from the ports is a PWM reversal in the middle of a dead interval, combined with a mode change inside that same interval. Both depend on landing an input change within a window only a few cycles long. The bench drives every input on the falling clock edge and counts cycles from a known steady state. This places the reversal exactly one cycle into the gap and the mode change one cycle after a gap starts. It then checks the cycle in which the surviving side turns on. Pulse widths on both sides of the preset length are then run to show the narrow pulse being swallowed and the wide one shortened by exactly N.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_DEAD = 2'd1,
    ST_HIGH = 2'd2,
    ST_LOW  = 2'd3
  } hbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic startDead;   // new interval: capture mode, side, clear count
    logic restartDead; // reversal: capture side, clear count, keep preset
    logic countStep;   // advance the interval counter
  } dpStrobe_t;

  localparam int unsigned NUM_PRESETS = 4;

endpackage

// File: rtl/hb_dt_datapath.sv
module hb_dt_datapath
  import hb_dt_pkg::*;
#(
  parameter int unsigned DEAD_CYC0 = 3,
  parameter int unsigned DEAD_CYC1 = 5,
  parameter int unsigned DEAD_CYC2 = 7,
  parameter int unsigned DEAD_CYC3 = 9,
  parameter int unsigned MODE_W    = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwmIn,
  input  logic [MODE_W-1:0] modeCode,
  input  dpStrobe_t         strobe,
  output logic              targetSide,
  output logic              countDone,
  output logic              shutReq
);

  localparam int unsigned MAX_A   = (DEAD_CYC0 > DEAD_CYC1) ? DEAD_CYC0 : DEAD_CYC1;
  localparam int unsigned MAX_B   = (DEAD_CYC2 > DEAD_CYC3) ? DEAD_CYC2 : DEAD_CYC3;
  localparam int unsigned MAX_CYC = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int unsigned CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;
  localparam int unsigned SEL_W   = $clog2(NUM_PRESETS);

  logic [CNT_W-1:0] presetLast [NUM_PRESETS];
  logic [CNT_W-1:0] count;
  logic [CNT_W-1:0] lastCnt;
  logic [CNT_W-1:0] selLast;
  logic [SEL_W-1:0] presetSel;

  // Last count value of each preset (interval length minus one)
  generate
    for (genvar gi = 0; gi < NUM_PRESETS; gi++) begin : g_preset
      localparam int unsigned CYC = (gi == 0) ? DEAD_CYC0 :
                                    (gi == 1) ? DEAD_CYC1 :
                                    (gi == 2) ? DEAD_CYC2 : DEAD_CYC3;
      assign presetLast[gi] = CNT_W'(CYC - 1);
    end
  endgenerate

  assign shutReq   = (modeCode >= MODE_W'(NUM_PRESETS));
  assign presetSel = modeCode[SEL_W-1:0];
  assign selLast   = presetLast[presetSel];

  always_ff @(posedge clk) begin
    if (rst) begin
      count      <= '0;
      lastCnt    <= presetLast[0];
      targetSide <= 1'b0;
    end else if (strobe.startDead) begin
      count      <= '0;
      lastCnt    <= selLast;
      targetSide <= pwmIn;
    end else if (strobe.restartDead) begin
      count      <= '0;
      targetSide <= pwmIn;
    end else if (strobe.countStep) begin
      count      <= count + CNT_W'(1);
    end
  end

  assign countDone = (count == lastCnt);

endmodule

// File: rtl/hb_dt_ctrl.sv
module hb_dt_ctrl
  import hb_dt_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      pwmIn,
  input  logic      blocked,
  input  logic      targetSide,
  input  logic      countDone,
  output dpStrobe_t strobe,
  output logic      hiEn,
  output logic      loEn
);

  hbState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (blocked) begin
      stateNext = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          strobe.startDead = 1'b1;
          stateNext        = ST_DEAD;
        end
        ST_DEAD: begin
          if (pwmIn != targetSide) begin
            strobe.restartDead = 1'b1;
          end else if (countDone) begin
            stateNext = targetSide ? ST_HIGH : ST_LOW;
          end else begin
            strobe.countStep = 1'b1;
          end
        end
        ST_HIGH: begin
          if (!pwmIn) begin
            strobe.startDead = 1'b1;
            stateNext        = ST_DEAD;
          end
        end
        ST_LOW: begin
          if (pwmIn) begin
            strobe.startDead = 1'b1;
            stateNext        = ST_DEAD;
          end
        end
        default: stateNext = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_OFF;
    else     state <= stateNext;
  end

  assign hiEn = (state == ST_HIGH);
  assign loEn = (state == ST_LOW);

endmodule

// File: rtl/halfbridge_deadtime.sv
module halfbridge_deadtime
  import hb_dt_pkg::*;
#(
  parameter int unsigned DEAD_CYC0 = 3,
  parameter int unsigned DEAD_CYC1 = 5,
  parameter int unsigned DEAD_CYC2 = 7,
  parameter int unsigned DEAD_CYC3 = 9
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwmIn,
  input  logic [2:0] modeCode,
  input  logic       uvFlag,
  output logic       hiEn,
  output logic       loEn
);

  dpStrobe_t strobe;
  logic      targetSide;
  logic      countDone;
  logic      shutReq;
  logic      blocked;

  assign blocked = uvFlag | shutReq;

  hb_dt_datapath #(
    .DEAD_CYC0(DEAD_CYC0),
    .DEAD_CYC1(DEAD_CYC1),
    .DEAD_CYC2(DEAD_CYC2),
    .DEAD_CYC3(DEAD_CYC3),
    .MODE_W   (3)
  ) dp_i (
    .clk       (clk),
    .rst       (rst),
    .pwmIn     (pwmIn),
    .modeCode  (modeCode),
    .strobe    (strobe),
    .targetSide(targetSide),
    .countDone (countDone),
    .shutReq   (shutReq)
  );

  hb_dt_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .pwmIn     (pwmIn),
    .blocked   (blocked),
    .targetSide(targetSide),
    .countDone (countDone),
    .strobe    (strobe),
    .hiEn      (hiEn),
    .loEn      (loEn)
  );

endmodule

// File: rtl/hb_dt_checker.sv
module hb_dt_checker (
  input logic       clk,
  input logic       rst,
  input logic       pwmIn,
  input logic [2:0] modeCode,
  input logic       uvFlag,
  input logic       hiEn,
  input logic       loEn
);

  AST_RESET_OFF: assert property (@(posedge clk)
    rst |=> (!hiEn && !loEn)); // R1

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(hiEn && loEn)); // R10

  AST_HI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    hiEn |-> $past(pwmIn)); // R2

  AST_LO_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    loEn |-> !$past(pwmIn)); // R2

  AST_SHUT_OFF: assert property (@(posedge clk) disable iff (rst)
    (modeCode >= 3'd4) |=> (!hiEn && !loEn)); // R6

  AST_UV_OFF: assert property (@(posedge clk) disable iff (rst)
    uvFlag |=> (!hiEn && !loEn)); // R7

  AST_GAP_BEFORE_LO: assert property (@(posedge clk) disable iff (rst)
    $rose(loEn) |-> !$past(hiEn)); // R3

  AST_GAP_BEFORE_HI: assert property (@(posedge clk) disable iff (rst)
    $rose(hiEn) |-> !$past(loEn)); // R3

endmodule

bind halfbridge_deadtime hb_dt_checker chk_i (
  .clk     (clk),
  .rst     (rst),
  .pwmIn   (pwmIn),
  .modeCode(modeCode),
  .uvFlag  (uvFlag),
  .hiEn    (hiEn),
  .loEn    (loEn)
);

// File: tb/halfbridge_deadtime_tb_top.sv
module halfbridge_deadtime_tb_top;

  logic       clk = 1'b0;
  logic       rst;
  logic       pwmIn;
  logic [2:0] modeCode;
  logic       uvFlag;
  logic       hiEn;
  logic       loEn;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  halfbridge_deadtime dut_i (
    .clk     (clk),
    .rst     (rst),
    .pwmIn   (pwmIn),
    .modeCode(modeCode),
    .uvFlag  (uvFlag),
    .hiEn    (hiEn),
    .loEn    (loEn)
  );

  // {pwm, mode[2:0], uv, expHi, expLo}; each applied for one edge from the off state
  localparam int NV = 28;
  localparam logic [6:0] VEC [0:NV-1] = '{
    7'b0_000_0_00, // R8 off -> dead, preset 3
    7'b0_000_0_00,
    7'b0_000_0_00,
    7'b0_000_0_01, // R4 low side after 3 cycles
    7'b1_000_0_00, // R3 high request, gap starts
    7'b1_000_0_00,
    7'b1_000_0_00,
    7'b1_000_0_10, // R3 high side after 3 cycles
    7'b1_011_0_10, // R5 mode change while on is ignored
    7'b0_011_0_00, // R4 gap of 9 starts
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_00,
    7'b0_011_0_01, // R4 low side after 9 cycles
    7'b0_001_1_00, // R7 undervoltage
    7'b0_001_0_00, // R8 recovery, preset 5
    7'b0_001_0_00,
    7'b0_001_0_00,
    7'b0_001_0_00,
    7'b0_001_0_00,
    7'b0_001_0_01, // R4 low side after 5 cycles
    7'b0_101_0_00, // R6 shutdown code 5
    7'b0_010_0_00  // R8 leaving shutdown
  };

  task automatic step(input logic r, input logic p, input logic [2:0] m, input logic u);
    rst      = r;
    pwmIn    = p;
    modeCode = m;
    uvFlag   = u;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic eh, input logic el, input string tag);
    nChecks++;
    if (hiEn !== eh || loEn !== el) begin
      nFails++;
      $display("FAIL %s hi/lo actual=%b%b expected=%b%b", tag, hiEn, loEn, eh, el);
    end
  endtask

  task automatic chkCount(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s high cycles actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial begin
    int hiCnt;
    rst = 1'b1; pwmIn = 1'b0; modeCode = 3'd0; uvFlag = 1'b0;
    @(negedge clk);
    step(1'b1, 1'b1, 3'd0, 1'b0);
    chk(1'b0, 1'b0, "R1 reset state");

    // table
    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][6], VEC[i][5:3], VEC[i][2]);
      chk(VEC[i][1], VEC[i][0], $sformatf("vector %0d (R2 R3 R4 R5 R6 R7 R8)", i));
    end

    // reset mid-interval, then full gap
    step(1'b1, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R1 reset mid-run");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R1 gap after reset");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R1 gap after reset");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R1 gap after reset");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b1, "R1 low side after reset gap");

    // reversal one cycle into a gap
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R9 gap starts");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R9 restart");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R9 counting");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b0, "R9 counting");
    step(1'b0, 1'b0, 3'd0, 1'b0); chk(1'b0, 1'b1, "R9 low side back after full gap");

    // preset change inside a gap
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R5 gap of 3 starts");
    step(1'b0, 1'b1, 3'd3, 1'b0); chk(1'b0, 1'b0, "R5 code changed in gap");
    step(1'b0, 1'b1, 3'd3, 1'b0); chk(1'b0, 1'b0, "R5 gap");
    step(1'b0, 1'b1, 3'd3, 1'b0); chk(1'b1, 1'b0, "R5 old preset kept");

    // shutdown while high, then recovery
    step(1'b0, 1'b1, 3'd4, 1'b0); chk(1'b0, 1'b0, "R6 shutdown from high");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R8 recovery gap");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R8 recovery gap");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R8 recovery gap");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b1, 1'b0, "R8 high after gap");

    // undervoltage while high, then recovery
    step(1'b0, 1'b1, 3'd0, 1'b1); chk(1'b0, 1'b0, "R7 undervoltage from high");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R8 uv recovery gap");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R8 uv recovery gap");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b0, 1'b0, "R8 uv recovery gap");
    step(1'b0, 1'b1, 3'd0, 1'b0); chk(1'b1, 1'b0, "R8 high after uv gap");

    // back to low conduction
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 3'd0, 1'b0);
    chk(1'b0, 1'b1, "R2 low side steady");

    // wide pulse L=6, N=3
    hiCnt = 0;
    for (int i = 0; i < 6; i++) begin
      step(1'b0, 1'b1, 3'd0, 1'b0);
      if (hiEn) hiCnt++;
    end
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 3'd0, 1'b0);
      if (hiEn) hiCnt++;
    end
    chkCount(hiCnt, 3, "R11 wide pulse");
    chk(1'b0, 1'b1, "R2 low side after pulse");

    // narrow pulse L=3, N=3
    hiCnt = 0;
    for (int i = 0; i < 3; i++) begin
      step(1'b0, 1'b1, 3'd0, 1'b0);
      if (hiEn) hiCnt++;
    end
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 1'b0, 3'd0, 1'b0);
      if (hiEn) hiCnt++;
    end
    chkCount(hiCnt, 0, "R11 narrow pulse swallowed");
    chk(1'b0, 1'b1, "R9 low side kept");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule